// File: doc/BRIEF.md
# Parallel NAND Identification Sequencer

This block identifies an 8-bit parallel NAND flash device attached to its pins. A one-cycle start pulse makes it select the device, send the reset command, wait out the device's busy period, and then run the identification command twice. Each run issues the command byte, one zero address byte and two data reads. The first byte read is the maker code and the second is the device code.

The two captured pairs are compared before anything is reported. A floating or bus-held data bus can return values that look credible once but rarely twice in the same way, so a result is only flagged as valid when all four bytes agree pairwise. Strobe pulse widths, the delay before the busy line is trusted and the busy timeout are parameters counted in clock cycles.

Top module: `nand_id_probe`

## Requirements
- R1: While reset is asserted and after it, before any start, chip enable, write strobe and read strobe are high, command latch, address latch, bus drive enable, busy and done are low.
- R2: After a start pulse the first byte latched by the device is 0xFF, presented with chip enable low, command latch high and address latch low.
- R3: After the reset command the block waits TWB cycles, then polls the ready/busy input and issues no further command until that input reads high.
- R4: The bytes latched on write-strobe rising edges, in order, are command 0x90, address 0x00, command 0x90, address 0x00 after the reset command; a command has command latch high and address latch low, an address the reverse.
- R5: The write strobe is low for exactly WE_LOW cycles per byte, the read strobe low for exactly RE_LOW cycles per read, and each read byte is sampled at the end of its read strobe low period; four reads occur per successful run.
- R6: The first byte read in each run is reported as the maker code and the second as the device code.
- R7: When both runs return identical pairs, id_ok is 1, mismatch is 0 and the codes of the first run are reported.
- R8: When either byte differs between the two runs, mismatch is 1, id_ok is 0 and both reported codes are 0x00.
- R9: If the ready/busy input stays low for RB_TIMEOUT polling cycles, the run ends with timeout set, id_ok and mismatch low, no read-ID command issued and no read performed.
- R10: Each run ends with done high for exactly one cycle, in the same cycle chip enable returns high; busy is high from the cycle after start until done.
- R11: A start pulse arriving while busy is high has no effect: no extra command is issued and no extra done pulse occurs.
- R12: The bus drive enable is high while a command or address byte is latched and is never high while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to probe the device |
| ce_n_o | output | 1 | Chip enable, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_n_o | output | 1 | Write strobe, active low |
| re_n_o | output | 1 | Read strobe, active low |
| dq_o | output | 8 | Byte driven onto the data bus |
| dq_oe_o | output | 1 | Data bus drive enable |
| dq_i | input | 8 | Byte sampled from the data bus |
| rb_n_i | input | 1 | Ready/busy from the device, low while busy |
| busy_o | output | 1 | Probe in progress |
| done_o | output | 1 | One-cycle end-of-run strobe |
| id_ok_o | output | 1 | Both captures matched |
| mismatch_o | output | 1 | Captures differed |
| timeout_o | output | 1 | Device never became ready |
| maker_id_o | output | 8 | Reported maker code |
| device_id_o | output | 8 | Reported device code |

## Verification
Bus-side results are due at the first falling clock edge after a write strobe rises or a read strobe falls, and the device model records or answers there, so latched bytes, strobe widths and drive-enable state are seen exactly when the device would see them. The status results (codes, flags, chip enable release) are all due in the single cycle where done is high, one cycle after the last read strobe period closes, and the monitor compares them against the queued expectation only at that falling edge. Busy is checked at the first falling edge after start is sampled, and the ignore case is checked by waiting well past the run and confirming the latch log and done count are unchanged.

// File: rtl/nidp_pkg.sv
package nidp_pkg;
  typedef enum logic [1:0] {
    BUS_CMD  = 2'd0,
    BUS_ADDR = 2'd1,
    BUS_READ = 2'd2
  } bus_op_e;

  localparam logic [7:0] CMD_RESET   = 8'hFF;
  localparam logic [7:0] CMD_READ_ID = 8'h90;
  localparam logic [7:0] ADDR_ID     = 8'h00;

  localparam int unsigned CAPTURES = 4;
  localparam int unsigned CAP_IW   = $clog2(CAPTURES);
endpackage

// File: rtl/nidp_bus_phy.sv
module nidp_bus_phy
  import nidp_pkg::*;
#(
  parameter int unsigned WE_LOW  = 2,
  parameter int unsigned WE_HIGH = 2,
  parameter int unsigned RE_LOW  = 3,
  parameter int unsigned RE_HIGH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  bus_op_e    op_i,
  input  logic [7:0] byte_i,
  input  logic [7:0] dq_i,
  output logic       cle_o,
  output logic       ale_o,
  output logic       we_n_o,
  output logic       re_n_o,
  output logic [7:0] dq_o,
  output logic       dq_oe_o,
  output logic       ack_o,
  output logic [7:0] rdata_o
);
  localparam int unsigned MAX_A = (WE_LOW > WE_HIGH) ? WE_LOW : WE_HIGH;
  localparam int unsigned MAX_B = (RE_LOW > RE_HIGH) ? RE_LOW : RE_HIGH;
  localparam int unsigned MAX_W = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CW    = $clog2(MAX_W + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rd_q, rd_d;
  logic          cle_q, cle_d, ale_q, ale_d, oe_q, oe_d;
  logic          we_n_q, we_n_d, re_n_q, re_n_d, ack_q, ack_d;
  logic [7:0]    dq_q, dq_d, rdat_q, rdat_d;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    rd_d   = rd_q;
    cle_d  = cle_q;
    ale_d  = ale_q;
    oe_d   = oe_q;
    we_n_d = we_n_q;
    re_n_d = re_n_q;
    dq_d   = dq_q;
    rdat_d = rdat_q;
    ack_d  = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_i) begin
          ph_d   = PH_LOW;
          rd_d   = (op_i == BUS_READ);
          cnt_d  = (op_i == BUS_READ) ? CW'(RE_LOW - 1) : CW'(WE_LOW - 1);
          cle_d  = (op_i == BUS_CMD);
          ale_d  = (op_i == BUS_ADDR);
          oe_d   = (op_i != BUS_READ);
          dq_d   = byte_i;
          we_n_d = (op_i == BUS_READ);
          re_n_d = (op_i != BUS_READ);
        end
      end
      PH_LOW: begin
        if (cnt_q == '0) begin
          ph_d   = PH_HIGH;
          cnt_d  = rd_q ? CW'(RE_HIGH - 1) : CW'(WE_HIGH - 1);
          we_n_d = 1'b1;
          re_n_d = 1'b1;
          if (rd_q) rdat_d = dq_i;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HIGH: begin
        if (cnt_q == '0) begin
          ph_d  = PH_IDLE;
          ack_d = 1'b1;
          cle_d = 1'b0;
          ale_d = 1'b0;
          oe_d  = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      cle_q  <= 1'b0;
      ale_q  <= 1'b0;
      oe_q   <= 1'b0;
      we_n_q <= 1'b1;
      re_n_q <= 1'b1;
      dq_q   <= '0;
      rdat_q <= '0;
      ack_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      rd_q   <= rd_d;
      cle_q  <= cle_d;
      ale_q  <= ale_d;
      oe_q   <= oe_d;
      we_n_q <= we_n_d;
      re_n_q <= re_n_d;
      dq_q   <= dq_d;
      rdat_q <= rdat_d;
      ack_q  <= ack_d;
    end
  end

  assign cle_o   = cle_q;
  assign ale_o   = ale_q;
  assign we_n_o  = we_n_q;
  assign re_n_o  = re_n_q;
  assign dq_o    = dq_q;
  assign dq_oe_o = oe_q;
  assign ack_o   = ack_q;
  assign rdata_o = rdat_q;

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_q && !re_n_q));
  assert_latch_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle_q && ale_q));
  assert_no_drive_on_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n_q |-> !oe_q);
  assert_req_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |-> (ph_q == PH_IDLE));
endmodule

// File: rtl/nidp_id_store.sv
module nidp_id_store
  import nidp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [CAP_IW-1:0] idx_i,
  input  logic [7:0]        byte_i,
  output logic [7:0]        maker_o,
  output logic [7:0]        device_o,
  output logic              match_o
);
  logic [7:0] slot_q [CAPTURES];

  for (genvar g = 0; g < CAPTURES; g++) begin : g_slot
    logic       en;
    logic [7:0] nxt;
    assign en  = clr_i || (wr_i && (idx_i == CAP_IW'(g)));
    assign nxt = clr_i ? 8'h00 : byte_i;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (en) slot_q[g] <= nxt;
    end
  end

  assign maker_o  = slot_q[0];
  assign device_o = slot_q[1];
  assign match_o  = (slot_q[0] == slot_q[2]) && (slot_q[1] == slot_q[3]);

  assert_no_clr_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_i && wr_i));
endmodule

// File: rtl/nidp_seq.sv
module nidp_seq
  import nidp_pkg::*;
#(
  parameter int unsigned TWB        = 4,
  parameter int unsigned RB_TIMEOUT = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rb_n_i,
  input  logic              ack_i,
  input  logic              match_i,
  input  logic [7:0]        maker_i,
  input  logic [7:0]        device_i,
  output logic              req_o,
  output bus_op_e           op_o,
  output logic [7:0]        byte_o,
  output logic              cap_clr_o,
  output logic              cap_wr_o,
  output logic [CAP_IW-1:0] cap_idx_o,
  output logic              ce_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              id_ok_o,
  output logic              mismatch_o,
  output logic              timeout_o,
  output logic [7:0]        maker_id_o,
  output logic [7:0]        device_id_o
);
  localparam int unsigned TMAX      = (TWB > RB_TIMEOUT) ? TWB : RB_TIMEOUT;
  localparam int unsigned TW        = $clog2(TMAX + 1);
  localparam int unsigned STEPS     = 9;
  localparam int unsigned SW        = $clog2(STEPS);
  localparam logic [SW-1:0] LAST_ST = SW'(STEPS - 1);
  localparam logic [SW-1:0] SEC_RUN = SW'(5);

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_TWB, S_POLL, S_FIN} st_e;

  st_e           st_q, st_d;
  logic [SW-1:0] step_q, step_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [1:0]    rb_sync_q;
  logic          rb_ready;
  logic          ce_n_q, ce_n_d, done_q, done_d;
  logic          ok_q, ok_d, mis_q, mis_d, to_q, to_d;
  logic [7:0]    mk_q, mk_d, dv_q, dv_d;
  logic          step_rd;

  // step decode: 0 reset, then two runs of {cmd, addr, read, read}
  always_comb begin
    op_o    = BUS_CMD;
    byte_o  = CMD_READ_ID;
    step_rd = 1'b0;
    unique case (step_q)
      SW'(0):        byte_o = CMD_RESET;
      SW'(1), SW'(5): byte_o = CMD_READ_ID;
      SW'(2), SW'(6): begin op_o = BUS_ADDR; byte_o = ADDR_ID; end
      default:       begin op_o = BUS_READ; byte_o = 8'h00; step_rd = 1'b1; end
    endcase
  end

  assign cap_idx_o = {step_q > SEC_RUN, (step_q == SW'(4)) || (step_q == SW'(8))};
  assign cap_wr_o  = (st_q == S_WAIT) && ack_i && step_rd;
  assign cap_clr_o = (st_q == S_IDLE) && start_i;
  assign req_o     = (st_q == S_ISSUE);
  assign rb_ready  = rb_sync_q[1];

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    tmr_d  = tmr_q;
    ce_n_d = ce_n_q;
    done_d = 1'b0;
    ok_d   = ok_q;
    mis_d  = mis_q;
    to_d   = to_q;
    mk_d   = mk_q;
    dv_d   = dv_q;
    unique case (st_q)
      S_IDLE: begin
        if (start_i) begin
          st_d   = S_ISSUE;
          step_d = '0;
          ce_n_d = 1'b0;
          ok_d   = 1'b0;
          mis_d  = 1'b0;
          to_d   = 1'b0;
          mk_d   = '0;
          dv_d   = '0;
        end
      end
      S_ISSUE: st_d = S_WAIT;
      S_WAIT: begin
        if (ack_i) begin
          if (step_q == '0) begin
            st_d  = S_TWB;
            tmr_d = TW'(TWB - 1);
          end else if (step_q == LAST_ST) begin
            st_d = S_FIN;
          end else begin
            st_d   = S_ISSUE;
            step_d = step_q + 1'b1;
          end
        end
      end
      S_TWB: begin
        if (tmr_q == '0) begin
          st_d  = S_POLL;
          tmr_d = TW'(RB_TIMEOUT - 1);
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      S_POLL: begin
        if (rb_ready) begin
          st_d   = S_ISSUE;
          step_d = SW'(1);
        end else if (tmr_q == '0) begin
          st_d   = S_IDLE;
          ce_n_d = 1'b1;
          done_d = 1'b1;
          to_d   = 1'b1;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      S_FIN: begin
        st_d   = S_IDLE;
        ce_n_d = 1'b1;
        done_d = 1'b1;
        ok_d   = match_i;
        mis_d  = !match_i;
        mk_d   = match_i ? maker_i : 8'h00;
        dv_d   = match_i ? device_i : 8'h00;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      step_q    <= '0;
      tmr_q     <= '0;
      rb_sync_q <= '0;
      ce_n_q    <= 1'b1;
      done_q    <= 1'b0;
      ok_q      <= 1'b0;
      mis_q     <= 1'b0;
      to_q      <= 1'b0;
      mk_q      <= '0;
      dv_q      <= '0;
    end else begin
      st_q      <= st_d;
      step_q    <= step_d;
      tmr_q     <= tmr_d;
      rb_sync_q <= {rb_sync_q[0], rb_n_i};
      ce_n_q    <= ce_n_d;
      done_q    <= done_d;
      ok_q      <= ok_d;
      mis_q     <= mis_d;
      to_q      <= to_d;
      mk_q      <= mk_d;
      dv_q      <= dv_d;
    end
  end

  assign ce_n_o      = ce_n_q;
  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = done_q;
  assign id_ok_o     = ok_q;
  assign mismatch_o  = mis_q;
  assign timeout_o   = to_q;
  assign maker_id_o  = mk_q;
  assign device_id_o = dv_q;

  assert_done_releases_ce_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ce_n_q);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_ok_excludes_mis_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_q && mis_q));
  assert_timeout_not_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |-> !ok_q);
  assert_req_with_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> !ce_n_q);
  assert_poll_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_POLL) && !rb_ready) |=> !req_o);
endmodule

// File: rtl/nand_id_probe.sv
module nand_id_probe
  import nidp_pkg::*;
#(
  parameter int unsigned WE_LOW     = 2,
  parameter int unsigned WE_HIGH    = 2,
  parameter int unsigned RE_LOW     = 3,
  parameter int unsigned RE_HIGH    = 2,
  parameter int unsigned TWB        = 4,
  parameter int unsigned RB_TIMEOUT = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output logic       ce_n_o,
  output logic       cle_o,
  output logic       ale_o,
  output logic       we_n_o,
  output logic       re_n_o,
  output logic [7:0] dq_o,
  output logic       dq_oe_o,
  input  logic [7:0] dq_i,
  input  logic       rb_n_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       id_ok_o,
  output logic       mismatch_o,
  output logic       timeout_o,
  output logic [7:0] maker_id_o,
  output logic [7:0] device_id_o
);
  logic              req, ack, match, cap_clr, cap_wr;
  bus_op_e           op;
  logic [7:0]        op_byte, rdata, cap_mk, cap_dv;
  logic [CAP_IW-1:0] cap_idx;

  nidp_seq #(.TWB(TWB), .RB_TIMEOUT(RB_TIMEOUT)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rb_n_i(rb_n_i),
    .ack_i(ack), .match_i(match), .maker_i(cap_mk), .device_i(cap_dv),
    .req_o(req), .op_o(op), .byte_o(op_byte), .cap_clr_o(cap_clr),
    .cap_wr_o(cap_wr), .cap_idx_o(cap_idx), .ce_n_o(ce_n_o),
    .busy_o(busy_o), .done_o(done_o), .id_ok_o(id_ok_o),
    .mismatch_o(mismatch_o), .timeout_o(timeout_o),
    .maker_id_o(maker_id_o), .device_id_o(device_id_o)
  );

  nidp_bus_phy #(.WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH),
                 .RE_LOW(RE_LOW), .RE_HIGH(RE_HIGH)) phy_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .op_i(op), .byte_i(op_byte),
    .dq_i(dq_i), .cle_o(cle_o), .ale_o(ale_o), .we_n_o(we_n_o),
    .re_n_o(re_n_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .ack_o(ack),
    .rdata_o(rdata)
  );

  nidp_id_store store_i (
    .clk(clk), .rst_n(rst_n), .clr_i(cap_clr), .wr_i(cap_wr),
    .idx_i(cap_idx), .byte_i(rdata), .maker_o(cap_mk),
    .device_o(cap_dv), .match_o(match)
  );

  assert_strobe_needs_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n_o || !re_n_o) |-> !ce_n_o);
  assert_latch_needs_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cle_o || ale_o) |-> !ce_n_o);
endmodule

// File: tb/nand_id_probe_tb_top.sv
`timescale 1ns/1ps
module nand_id_probe_tb_top;
  localparam int unsigned P_WE_LOW  = 2;
  localparam int unsigned P_WE_HIGH = 2;
  localparam int unsigned P_RE_LOW  = 3;
  localparam int unsigned P_RE_HIGH = 2;
  localparam int unsigned P_TWB     = 4;
  localparam int unsigned P_TMO     = 200;

  logic clk, rst_n, start_i;
  logic ce_n_o, cle_o, ale_o, we_n_o, re_n_o, dq_oe_o;
  logic [7:0] dq_o, dq_i;
  logic rb_n_i, busy_o, done_o, id_ok_o, mismatch_o, timeout_o;
  logic [7:0] maker_id_o, device_id_o;

  nand_id_probe #(.WE_LOW(P_WE_LOW), .WE_HIGH(P_WE_HIGH), .RE_LOW(P_RE_LOW),
                  .RE_HIGH(P_RE_HIGH), .TWB(P_TWB), .RB_TIMEOUT(P_TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ce_n_o(ce_n_o),
    .cle_o(cle_o), .ale_o(ale_o), .we_n_o(we_n_o), .re_n_o(re_n_o),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dq_i(dq_i), .rb_n_i(rb_n_i),
    .busy_o(busy_o), .done_o(done_o), .id_ok_o(id_ok_o),
    .mismatch_o(mismatch_o), .timeout_o(timeout_o),
    .maker_id_o(maker_id_o), .device_id_o(device_id_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic       ok, mis, to;
    logic [7:0] mk, dv;
    logic [3:0] nlat;
  } exp_t;

  exp_t        exp_q[$];
  logic [10:0] lat_q[$];
  int checks = 0, fails = 0;
  int done_seen = 0;

  // device model state
  logic [7:0] rd_val [4];
  bit  stuck = 0;
  int  busy_len = 10, busy_left = 0;
  int  rd_idx = 0, neg_cnt = 0, rb_rise_at = -1, first90_at = -1;
  int  we_run = 0, re_run = 0, width_err = 0, oe_err = 0;
  logic we_prev = 1'b1, re_prev = 1'b1;

  task automatic chk(input bit cond, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // device model: records latched bytes, answers reads, drives ready/busy
  always @(negedge clk) begin
    neg_cnt++;
    if (rst_n) begin
      if (!we_n_o) we_run++;
      else if (!we_prev) begin
        if (we_run != P_WE_LOW) width_err++;
        we_run = 0;
        lat_q.push_back({dq_oe_o, cle_o, ale_o, dq_o});
        if (cle_o && dq_o == 8'hFF) begin rb_n_i = 1'b0; busy_left = busy_len; end
        if (cle_o && dq_o == 8'h90 && first90_at < 0) first90_at = neg_cnt;
      end else if (!rb_n_i && !stuck) begin
        if (busy_left == 0) begin rb_n_i = 1'b1; rb_rise_at = neg_cnt; end
        else busy_left--;
      end
      if (!re_n_o) begin
        re_run++;
        if (dq_oe_o) oe_err++;
        if (re_prev) dq_i = (rd_idx < 4) ? rd_val[rd_idx] : 8'hEE;
      end else if (!re_prev) begin
        if (re_run != P_RE_LOW) width_err++;
        re_run = 0;
        rd_idx++;
      end
    end
    we_prev = we_n_o;
    re_prev = re_n_o;
  end

  // monitor / scoreboard
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (done_prev) chk(0, "R10", "done longer than one cycle", 1, 0);
      if (exp_q.size() == 0) begin
        chk(0, "R11", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(ce_n_o == 1'b1, "R10", "ce_n at done", 32'(ce_n_o), 1);
        chk(id_ok_o == e.ok, "R7", "id_ok", 32'(id_ok_o), 32'(e.ok));
        chk(mismatch_o == e.mis, "R8", "mismatch", 32'(mismatch_o), 32'(e.mis));
        chk(timeout_o == e.to, "R9", "timeout", 32'(timeout_o), 32'(e.to));
        chk(maker_id_o == e.mk, "R6", "maker", 32'(maker_id_o), 32'(e.mk));
        chk(device_id_o == e.dv, "R6", "device", 32'(device_id_o), 32'(e.dv));
        chk(lat_q.size() == int'(e.nlat), "R4", "latched count",
            32'(lat_q.size()), 32'(e.nlat));
        if (lat_q.size() >= 1)
          chk(lat_q[0] == {3'b110, 8'hFF}, "R2", "first latch", 32'(lat_q[0]), 32'h6FF);
        if (e.nlat == 4'd5 && lat_q.size() == 5) begin
          for (int k = 1; k < 5; k++) begin
            logic [10:0] want;
            want = (k % 2 == 1) ? {3'b110, 8'h90} : {3'b101, 8'h00};
            chk(lat_q[k] == want, "R4", "latch sequence", 32'(lat_q[k]), 32'(want));
          end
          chk(rb_rise_at >= 0 && first90_at > rb_rise_at, "R3",
              "read-ID after ready", 32'(first90_at), 32'(rb_rise_at));
        end
        chk(rd_idx == (e.to ? 0 : 4), "R5", "read count", 32'(rd_idx),
            e.to ? 0 : 4);
        chk(width_err == 0, "R5", "strobe width errors", 32'(width_err), 0);
        chk(oe_err == 0, "R12", "drive while reading", 32'(oe_err), 0);
      end
      done_seen++;
    end
    done_prev = done_o;
  end

  task automatic run_probe(input logic [7:0] m0, input logic [7:0] d0,
                           input logic [7:0] m1, input logic [7:0] d1,
                           input bit stk, input int blen, input bit restart,
                           input bit ok, input bit mis, input bit to);
    exp_t e;
    int   seen0;
    rd_val[0] = m0; rd_val[1] = d0; rd_val[2] = m1; rd_val[3] = d1;
    stuck = stk; busy_len = blen; rb_n_i = 1'b1;
    lat_q.delete();
    rd_idx = 0; rb_rise_at = -1; first90_at = -1; width_err = 0; oe_err = 0;
    e.ok = ok; e.mis = mis; e.to = to;
    e.mk = ok ? m0 : 8'h00; e.dv = ok ? d0 : 8'h00;
    e.nlat = to ? 4'd1 : 4'd5;
    exp_q.push_back(e);
    seen0 = done_seen;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(busy_o == 1'b1, "R10", "busy after start", 32'(busy_o), 1);
    if (restart) begin
      repeat (20) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
    end
    for (int w = 0; w < 5000 && done_seen == seen0; w++) @(negedge clk);
    if (done_seen == seen0) begin
      chk(0, "R10", "watchdog: no done", 0, 1);
      void'(exp_q.pop_front());
    end
    repeat (40) @(negedge clk);
    if (restart) begin
      chk(done_seen == seen0 + 1, "R11", "done count", 32'(done_seen), 32'(seen0 + 1));
      chk(lat_q.size() == 5, "R11", "latches after ignored start",
          32'(lat_q.size()), 5);
    end
    chk(busy_o == 1'b0, "R10", "idle after run", 32'(busy_o), 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; rb_n_i = 1'b1; dq_i = 8'h00;
    repeat (4) @(negedge clk);
    chk(ce_n_o && we_n_o && re_n_o, "R1", "strobes in reset",
        32'({ce_n_o, we_n_o, re_n_o}), 7);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!cle_o && !ale_o && !dq_oe_o && !busy_o && !done_o, "R1", "idle levels",
        32'({cle_o, ale_o, dq_oe_o, busy_o, done_o}), 0);
    chk(ce_n_o == 1'b1, "R1", "ce_n idle", 32'(ce_n_o), 1);

    run_probe(8'hEC, 8'hD3, 8'hEC, 8'hD3, 0, 10, 0, 1, 0, 0); // R7 match
    run_probe(8'h2C, 8'hDA, 8'h2C, 8'hDA, 0, 3,  0, 1, 0, 0); // R6 order
    run_probe(8'h98, 8'hF1, 8'h98, 8'hF0, 0, 6,  0, 0, 1, 0); // R8 device differs
    run_probe(8'h01, 8'hA1, 8'h81, 8'hA1, 0, 6,  0, 0, 1, 0); // R8 maker differs
    run_probe(8'hEC, 8'hD3, 8'hEC, 8'hD3, 1, 0,  0, 0, 0, 1); // R9 timeout
    run_probe(8'hAD, 8'h75, 8'hAD, 8'h75, 0, 25, 1, 1, 0, 0); // R11 restart ignored

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule